// File: doc/BRIEF.md
# Relocatable Microsecond Countdown Timer

This block is a 16-bit countdown timer that software reaches through a four-byte I/O window. The window's base address sits in a base register that can be moved at run time. The same register carries an enable bit, and the window is decoded only while that bit is set. Software loads a reload latch in microsecond units. It can do this with two byte writes or with a single 16-bit write. Every latch write restarts the countdown from the whole latch value.

A tick input that pulses once per microsecond drives the countdown. Reads from the window return the live remaining count, not the latch. When the count steps from one to zero, the block raises a one-cycle expiry pulse. A separate configuration port loads the base register a byte at a time.

Top module: `reloc_us_timer`

## Requirements
- R1: After reset the base register holds 0x0078 with the enable bit (bit 0) clear. No access is claimed, and the expiry output is low.
- R2: An access is claimed only while base bit 0 is set and address bits [15:2] equal base bits [15:2]. An unclaimed read returns rd_valid low and rd_data 0xFFFF. An unclaimed write leaves the latch and the count unchanged.
- R3: Bit 1 of the low base byte is forced to zero whatever value is written, so a low byte of 0x7B opens the window at 0x0078.
- R4: Accesses at window offsets 2 and 3 are claimed but ignored on write and return 0xFFFF on read. A 16-bit access at offset 1 is also ignored on write and returns 0xFFFF on read.
- R5: A byte write (data on io_wdata[7:0]) at offset 0 replaces the latch low byte, and at offset 1 the latch high byte. Either write restarts the count from the resulting full latch.
- R6: A 16-bit write at offset 0 loads the whole latch from io_wdata and restarts the count from it.
- R7: A byte read at offset 0 or 1 returns the low or high byte of the remaining count in rd_data[7:0], with rd_data[15:8] zero. A 16-bit read at offset 0 returns the full remaining count. rd_valid and rd_data appear one cycle after the read request.
- R8: The count decrements by one on each clock with tick_us high and stops at zero without wrapping.
- R9: expired is high for exactly one cycle, the cycle after the tick that takes the count from one to zero. Loading a zero latch does not raise it.
- R10: A base register write takes effect from the next cycle. An access in the same cycle as the write still decodes against the old base. After the move, the old address is no longer claimed.
- R11: When a latch write and a tick occur in the same cycle, the write wins and the count equals the new latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Base register byte write strobe |
| cfg_hi | input | 1 | Selects the high (1) or low (0) base byte |
| cfg_wdata | input | 8 | Base byte value |
| io_wr | input | 1 | I/O write request |
| io_rd | input | 1 | I/O read request |
| io_wide | input | 1 | 16-bit access when high, byte access when low |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| tick_us | input | 1 | One-microsecond tick enable |
| rd_valid | output | 1 | Registered: the previous cycle's read was claimed |
| rd_data | output | 16 | Registered read data |
| expired | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit word and a reset base of 0x0078. These give the exact address map and byte-lane split that the requirements state. Because the tick is driven directly by the bench rather than divided from the clock, a countdown can be walked one microsecond at a time. This puts the one-to-zero step, the hold at zero and a load that coincides with a tick within a few cycles. Relocation is exercised by moving the base across the address space, including a move issued in the same cycle as an access.

// File: rtl/rut_pkg.sv
package rut_pkg;
  localparam int OFF_W = 2;

  typedef struct packed {
    logic             hit;
    logic [OFF_W-1:0] off;
  } rut_acc_t;
endpackage

// File: rtl/rut_base_reg.sv
module rut_base_reg #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W,
  parameter logic [WORD_W-1:0] BASE_RST = 16'h0078
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_hi,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] base_q
);
  localparam logic [BYTE_W-1:0] LO_MASK = ~(BYTE_W'(2));

  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= BASE_RST[BYTE_W-1:0] & LO_MASK;
      hi_q <= BASE_RST[WORD_W-1:BYTE_W];
    end else if (cfg_we) begin
      if (cfg_hi) hi_q <= cfg_wdata;
      else        lo_q <= cfg_wdata & LO_MASK;
    end
  end

  assign base_q = {hi_q, lo_q};
endmodule

// File: rtl/rut_decode.sv
module rut_decode
  import rut_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] base_q,
  input  logic [WORD_W-1:0] addr,
  output rut_acc_t          acc
);
  logic en;
  assign en = base_q[0];

  always_comb begin
    acc.hit = en && (addr[WORD_W-1:OFF_W] == base_q[WORD_W-1:OFF_W]);
    acc.off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/rut_counter.sv
module rut_counter #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int WORD_W = LANES * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0]            we,
  input  logic [LANES-1:0][BYTE_W-1:0] wd,
  input  logic                        tick,
  output logic [WORD_W-1:0]           count,
  output logic                        expired
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [LANES-1:0][BYTE_W-1:0] latch_q, latch_nx;
  logic load;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign latch_nx[g] = we[g] ? wd[g] : latch_q[g];
    always_ff @(posedge clk) begin
      if (rst)        latch_q[g] <= '0;
      else if (we[g]) latch_q[g] <= wd[g];
    end
  end

  assign load = |we;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      expired <= 1'b0;
    end else begin
      expired <= !load && tick && (count == ONE);
      if (load)                      count <= latch_nx;
      else if (tick && count != '0)  count <= count - ONE;
    end
  end

  // R8
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && tick && count != '0) |=> (count == $past(count) - ONE));
  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && count == '0) |=> (count == '0));
  // R9
  expiry_single_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
  // R9
  expiry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    expired |-> (count == '0));
  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == latch_q));
endmodule

// File: rtl/rut_rdport.sv
module rut_rdport
  import rut_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wide,
  input  rut_acc_t          acc,
  input  logic [WORD_W-1:0] count,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] sel;

  always_comb begin
    if (acc.off[1])
      sel = '1;
    else if (wide)
      sel = acc.off[0] ? '1 : count;
    else
      sel = {{BYTE_W{1'b0}}, acc.off[0] ? count[WORD_W-1:BYTE_W] : count[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '1;
    end else if (rd && acc.hit) begin
      rd_valid <= 1'b1;
      rd_data  <= sel;
    end else begin
      rd_valid <= 1'b0;
      rd_data  <= '1;
    end
  end
endmodule

// File: rtl/reloc_us_timer.sv
module reloc_us_timer
  import rut_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] BASE_RST = 16'h0078
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_hi,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic                io_wide,
  input  logic [2*BYTE_W-1:0] io_addr,
  input  logic [2*BYTE_W-1:0] io_wdata,
  input  logic                tick_us,
  output logic                rd_valid,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic                expired
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0]          base_q;
  logic [WORD_W-1:0]          count;
  rut_acc_t                   acc;
  logic                       wr_ok;
  logic [1:0]                 we;
  logic [1:0][BYTE_W-1:0]     wd;

  rut_base_reg #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .BASE_RST(BASE_RST)) u_base (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
    .cfg_wdata(cfg_wdata), .base_q(base_q)
  );

  rut_decode #(.WORD_W(WORD_W)) u_dec (
    .base_q(base_q), .addr(io_addr), .acc(acc)
  );

  assign wr_ok = io_wr && acc.hit && !acc.off[1];
  assign we[0] = wr_ok && !acc.off[0];
  assign we[1] = wr_ok && (io_wide ? !acc.off[0] : acc.off[0]);
  assign wd[0] = io_wdata[BYTE_W-1:0];
  assign wd[1] = io_wide ? io_wdata[WORD_W-1:BYTE_W] : io_wdata[BYTE_W-1:0];

  rut_counter #(.BYTE_W(BYTE_W), .LANES(2), .WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .we(we), .wd(wd), .tick(tick_us),
    .count(count), .expired(expired)
  );

  rut_rdport #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .rd(io_rd), .wide(io_wide), .acc(acc),
    .count(count), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7
  rd_claim_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(io_rd));
  // R4
  rd_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(io_addr[1])) |-> (&rd_data));
  // R2
  idle_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (&rd_data));
endmodule

// File: tb/sim_reloc_us_timer.sv
module sim_reloc_us_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_wide = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic        tick_us = 1'b0;
  logic        rd_valid, expired;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  bit          pend = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  reloc_us_timer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide), .io_addr(io_addr),
    .io_wdata(io_wdata), .tick_us(tick_us), .rd_valid(rd_valid),
    .rd_data(rd_data), .expired(expired)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input bit hi, input logic [7:0] v);
    cfg_we = 1'b1; cfg_hi = hi; cfg_wdata = v;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input bit wide);
    io_wr = 1'b1; io_addr = a; io_wdata = d; io_wide = wide;
    cyc();
    io_wr = 1'b0; io_wide = 1'b0;
  endtask

  // Driver: pushes the expected {rd_valid, rd_data} and issues the read
  task automatic rd(input logic [15:0] a, input bit wide, input bit v,
                    input logic [15:0] d, input string tag);
    exp_q.push_back({v, d});
    tag_q.push_back(tag);
    io_rd = 1'b1; io_addr = a; io_wide = wide;
    cyc();
    io_rd = 1'b0; io_wide = 1'b0;
  endtask

  task automatic tick();
    tick_us = 1'b1;
    cyc();
    tick_us = 1'b0;
  endtask

  // Monitor: compares the registered read result one cycle after each read
  initial forever begin
    @(negedge clk);
    if (pend) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 0, 1);
      else check(tag_q.pop_front(), {15'd0, rd_valid, rd_data}, {15'd0, exp_q.pop_front()});
    end
    pend = io_rd;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      check("watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 expired low", {31'd0, expired}, 0);
    rd(16'h0078, 1'b1, 1'b0, 16'hFFFF, "R1 disabled window");

    // R3: bit 1 of the low byte written set, window still at 0x78
    cfg(1'b0, 8'h7B);
    cfg(1'b1, 8'h00);
    wr(16'h0078, 16'h1234, 1'b1);
    rd(16'h0078, 1'b1, 1'b1, 16'h1234, "R6 wide load / R3 window");
    rd(16'h0079, 1'b0, 1'b1, 16'h0012, "R7 high byte");
    rd(16'h0078, 1'b0, 1'b1, 16'h0034, "R7 low byte");

    repeat (3) tick();
    rd(16'h0078, 1'b1, 1'b1, 16'h1231, "R8 three ticks");

    wr(16'h0078, 16'h00AB, 1'b0);
    rd(16'h0078, 1'b1, 1'b1, 16'h12AB, "R5 low byte restart");
    wr(16'h0079, 16'h0000, 1'b0);
    rd(16'h0078, 1'b1, 1'b1, 16'h00AB, "R5 high byte restart");

    wr(16'h007A, 16'h5555, 1'b1);
    wr(16'h007B, 16'h0055, 1'b0);
    wr(16'h0079, 16'h7777, 1'b1);
    rd(16'h0078, 1'b1, 1'b1, 16'h00AB, "R4 writes ignored");
    rd(16'h007B, 1'b0, 1'b1, 16'hFFFF, "R4 offset 3 read");
    rd(16'h007A, 1'b1, 1'b1, 16'hFFFF, "R4 offset 2 read");
    rd(16'h0079, 1'b1, 1'b1, 16'hFFFF, "R4 wide offset 1 read");

    wr(16'h007C, 16'h0001, 1'b1);
    rd(16'h0078, 1'b1, 1'b1, 16'h00AB, "R2 unclaimed write ignored");
    rd(16'h007C, 1'b1, 1'b0, 16'hFFFF, "R2 outside window");

    // R9 expiry
    wr(16'h0078, 16'h0002, 1'b1);
    tick();
    check("R9 no pulse at one", {31'd0, expired}, 0);
    tick();
    check("R9 pulse at zero", {31'd0, expired}, 1);
    cyc();
    check("R9 pulse one cycle", {31'd0, expired}, 0);
    tick();
    check("R9 no pulse at hold", {31'd0, expired}, 0);
    rd(16'h0078, 1'b1, 1'b1, 16'h0000, "R8 stops at zero");

    wr(16'h0078, 16'h0000, 1'b1);
    check("R9 zero load no pulse", {31'd0, expired}, 0);
    tick();
    check("R9 zero load tick no pulse", {31'd0, expired}, 0);

    // R11 write and tick together
    io_wr = 1'b1; io_wide = 1'b1; io_addr = 16'h0078; io_wdata = 16'h0010; tick_us = 1'b1;
    cyc();
    io_wr = 1'b0; io_wide = 1'b0; tick_us = 1'b0;
    rd(16'h0078, 1'b1, 1'b1, 16'h0010, "R11 write wins over tick");

    // R10 relocation
    cfg(1'b1, 8'h12);
    cfg(1'b0, 8'h41);
    rd(16'h0078, 1'b1, 1'b0, 16'hFFFF, "R10 old address unclaimed");
    rd(16'h1240, 1'b1, 1'b1, 16'h0010, "R10 new address");
    exp_q.push_back({1'b1, 16'h0010});
    tag_q.push_back("R10 same-cycle access uses old base");
    cfg_we = 1'b1; cfg_hi = 1'b0; cfg_wdata = 8'h81;
    io_rd = 1'b1; io_wide = 1'b1; io_addr = 16'h1240;
    cyc();
    cfg_we = 1'b0; io_rd = 1'b0; io_wide = 1'b0;
    rd(16'h1280, 1'b1, 1'b1, 16'h0010, "R10 moved base");
    rd(16'h1240, 1'b1, 1'b0, 16'hFFFF, "R10 previous base unclaimed");
    cfg(1'b0, 8'h80);
    rd(16'h1280, 1'b1, 1'b0, 16'hFFFF, "R2 enable cleared");

    repeat (3) cyc();
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule